// File: doc/BRIEF.md
# Command and Readback Serial Slave for a Sampling Converter

This block is the two-wire serial front end of a sampling converter. It watches an oversampled clock line and data line, recognises bus start and stop conditions, and answers one 7-bit device address whose low two bits come from strap pins. A write transfer carries a single command byte. The block decodes that byte into a channel selector, a power-down code and a resolution flag, and drives two single-cycle strobes to the conversion sequencer. One strobe opens the acquisition window and the other closes it.

A read transfer returns the converter result held on `result_i`. In 12-bit mode the result goes out as a high byte and a padded low byte. In 8-bit mode it goes out as one byte. The block keeps sending bytes for as long as the master acknowledges them. The data line is open-drain: `sda_oe_o` high means the block pulls the line low.

The acquisition window follows bus events. It opens on the clock falling edge that ends the fourth command bit. It closes at the next stop or start condition.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After reset, `sda_oe_o` is low, `chan_o`, `pd_o` and `res8_o` are zero, and neither strobe is high.
- R2: The address byte is sent MSB first and is 1,0,0,1,0, then `strap_i[1]`, then `strap_i[0]`, then the direction bit (1 = read, 0 = write). The block pulls SDA low in the ninth clock only when all seven address bits match. On a mismatch it stays off the bus until the next start or stop.
- R3: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. Data bits are taken on SCL rising edges, and a stop releases SDA.
- R4: In the command byte, bits 7:4 are the channel, bits 3:2 are the power-down code, bit 1 is the mode (1 = 8-bit, 0 = 12-bit), and bit 0 is ignored. `chan_o` changes only together with `acq_start_o`. `pd_o` and `res8_o` take their new values at the end of the byte.
- R5: `acq_start_o` pulses for one cycle on the SCL falling edge that follows the fourth bit of the first command byte of a write transfer.
- R6: `acq_end_o` pulses for one cycle at the first start or stop condition after `acq_start_o`, and never without an open window.
- R7: Only the first data byte of a write transfer is acknowledged. A later byte is not acknowledged and does not change `chan_o`, `pd_o` or `res8_o`.
- R8: In 12-bit mode a read returns `result_i[11:4]`, then `{result_i[3:0],4'b0000}`. `result_i` is captured at the address acknowledge.
- R9: In 8-bit mode a read returns `result_i[11:4]` as its single result byte, and every further acknowledged byte repeats it.
- R10: After a master acknowledge the next byte follows; in 12-bit mode the bytes alternate high and low. After a master not-acknowledge SDA stays released until a start or stop.
- R11: A repeated start in the middle of a byte discards the partial bits and restarts address reception.
- R12: `sda_oe_o` changes only in response to an SCL falling edge or a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | High to pull the data line low |
| strap_i | input | 2 | Low two address bits from strap pins |
| result_i | input | 12 | Converter result for readback |
| chan_o | output | 4 | Decoded channel selector |
| pd_o | output | 2 | Decoded power-down code |
| res8_o | output | 1 | 1 selects 8-bit readback, 0 selects 12-bit |
| acq_start_o | output | 1 | One-cycle strobe that opens acquisition |
| acq_end_o | output | 1 | One-cycle strobe that closes acquisition |

## Verification
The bench counts strobes bit by bit through the command byte. A block that opened acquisition at the end of the byte, or one edge early, fails the checks made after the third and fourth bits. Extra command bytes are sent to catch a block that acknowledges them or lets them overwrite the fields. Repeated starts are issued in the middle of an address byte and in the middle of an open window. This catches a block that keeps stale bits, or one that fails to close the window without a stop. Random reads in both modes catch a wrong low-byte padding and the wrong byte after a master acknowledge in 8-bit mode. They also catch SDA held low after a not-acknowledge.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } bus_st_e;

    localparam int BYTE_W  = 8;
    localparam int CHAN_W  = 4;
    localparam int PD_W    = 2;
    localparam int STRAP_W = 2;
    localparam int PFX_W   = BYTE_W - 1 - STRAP_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/i2c_cmd_sync.sv
module i2c_cmd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_cmd_events.sv
module i2c_cmd_events
    import i2c_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop,
    output logic sda_lvl
);

    bus_ev_t ev_d, ev_q;

    always_comb begin
        ev_d       = ev_q;
        ev_d.scl_p = scl_s;
        ev_d.sda_p = sda_s;
        ev_d.rise  = scl_s & ~ev_q.scl_p;
        ev_d.fall  = ~scl_s & ev_q.scl_p;
        ev_d.start = scl_s & ev_q.scl_p & ev_q.sda_p & ~sda_s;
        ev_d.stop  = scl_s & ev_q.scl_p & ~ev_q.sda_p & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '{scl_p: 1'b1, sda_p: 1'b1, default: 1'b0};
        else        ev_q <= ev_d;
    end

    assign ev_rise  = ev_q.rise;
    assign ev_fall  = ev_q.fall;
    assign ev_start = ev_q.start;
    assign ev_stop  = ev_q.stop;
    assign sda_lvl  = ev_q.sda_p;

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int               RES_W       = 12,
    parameter logic [PFX_W-1:0] ADDR_PREFIX = 5'b10010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_rise,
    input  logic               ev_fall,
    input  logic               ev_start,
    input  logic               ev_stop,
    input  logic               sda_lvl,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [RES_W-1:0]   result_i,
    output logic               sda_oe_o,
    output logic [CHAN_W-1:0]  chan_o,
    output logic [PD_W-1:0]    pd_o,
    output logic               res8_o,
    output logic               acq_start_o,
    output logic               acq_end_o
);

    localparam int          PAD_W     = 2 * BYTE_W - RES_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_CHAN = CNT_W'(CHAN_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        bus_st_e                 state;
        logic [CNT_W-1:0]        bitcnt;
        logic [BYTE_W-1:0]       rx;
        logic [BYTE_W-1:0]       tx;
        logic                    rw;
        logic                    cmd_seen;
        logic                    acked;
        logic                    mack;
        logic                    acq_open;
        logic                    byte_sel;
        logic [RES_W-1:0]        snap;
        logic                    oe;
        logic [CHAN_W-1:0]       chan;
        logic [PD_W-1:0]         pd;
        logic                    res8;
        logic                    acq_start;
        logic                    acq_end;
    } eng_t;

    eng_t r_q, r_d;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [RES_W-1:0] val,
                                                    input logic sel_lo);
        logic [2*BYTE_W-1:0] wide;
        wide = (2*BYTE_W)'(val) << PAD_W;
        return sel_lo ? wide[BYTE_W-1:0] : wide[2*BYTE_W-1:BYTE_W];
    endfunction

    always_comb begin
        logic [BYTE_W-1:0] nb;
        logic              nsel;
        r_d           = r_q;
        r_d.acq_start = 1'b0;
        r_d.acq_end   = 1'b0;
        nb            = '0;
        nsel          = 1'b0;
        if (ev_start || ev_stop) begin
            if (r_q.acq_open) begin
                r_d.acq_end  = 1'b1;
                r_d.acq_open = 1'b0;
            end
            r_d.oe       = 1'b0;
            r_d.bitcnt   = '0;
            r_d.cmd_seen = 1'b0;
            r_d.state    = ev_start ? ST_ADDR : ST_IDLE;
        end else begin
            case (r_q.state)
                ST_ADDR: begin
                    if (ev_rise && r_q.bitcnt < CNT_FULL) begin
                        r_d.rx     = {r_q.rx[BYTE_W-2:0], sda_lvl};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (ev_fall && r_q.bitcnt == CNT_FULL) begin
                        if (r_q.rx[BYTE_W-1 -: PFX_W] == ADDR_PREFIX &&
                            r_q.rx[STRAP_W:1] == strap_i) begin
                            r_d.oe    = 1'b1;
                            r_d.rw    = r_q.rx[0];
                            r_d.state = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            nb           = pick_byte(result_i, 1'b0);
                            r_d.snap     = result_i;
                            r_d.byte_sel = 1'b0;
                            r_d.tx       = nb;
                            r_d.oe       = ~nb[BYTE_W-1];
                            r_d.state    = ST_RD;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (ev_rise && r_q.bitcnt < CNT_FULL) begin
                        r_d.rx     = {r_q.rx[BYTE_W-2:0], sda_lvl};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (ev_fall) begin
                        if (r_q.bitcnt == CNT_CHAN && !r_q.cmd_seen) begin
                            r_d.acq_start = 1'b1;
                            r_d.acq_open  = 1'b1;
                            r_d.chan      = r_q.rx[CHAN_W-1:0];
                        end
                        if (r_q.bitcnt == CNT_FULL) begin
                            r_d.acked = ~r_q.cmd_seen;
                            r_d.oe    = ~r_q.cmd_seen;
                            if (!r_q.cmd_seen) begin
                                r_d.cmd_seen = 1'b1;
                                r_d.pd       = r_q.rx[BYTE_W-CHAN_W-1 -: PD_W];
                                r_d.res8     = r_q.rx[1];
                            end
                            r_d.state = ST_WR_ACK;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev_fall) begin
                        r_d.oe     = 1'b0;
                        r_d.bitcnt = '0;
                        r_d.state  = r_q.acked ? ST_WR : ST_HOLD;
                    end
                end
                ST_RD: begin
                    if (ev_fall) begin
                        if (r_q.bitcnt == CNT_LAST) begin
                            r_d.oe     = 1'b0;
                            r_d.bitcnt = '0;
                            r_d.state  = ST_RD_ACK;
                        end else begin
                            r_d.tx     = {r_q.tx[BYTE_W-2:0], 1'b0};
                            r_d.oe     = ~r_q.tx[BYTE_W-2];
                            r_d.bitcnt = r_q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_lvl;
                    end else if (ev_fall) begin
                        if (r_q.mack) begin
                            nsel         = r_q.res8 ? 1'b0 : ~r_q.byte_sel;
                            nb           = pick_byte(r_q.snap, nsel);
                            r_d.byte_sel = nsel;
                            r_d.tx       = nb;
                            r_d.oe       = ~nb[BYTE_W-1];
                            r_d.bitcnt   = '0;
                            r_d.state    = ST_RD;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe_o    = r_q.oe;
    assign chan_o      = r_q.chan;
    assign pd_o        = r_q.pd;
    assign res8_o      = r_q.res8;
    assign acq_start_o = r_q.acq_start;
    assign acq_end_o   = r_q.acq_end;

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
    import i2c_cmd_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               RES_W       = 12,
    parameter logic [PFX_W-1:0] ADDR_PREFIX = 5'b10010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [RES_W-1:0]   result_i,
    output logic [CHAN_W-1:0]  chan_o,
    output logic [PD_W-1:0]    pd_o,
    output logic               res8_o,
    output logic               acq_start_o,
    output logic               acq_end_o
);

    logic scl_s, sda_s;
    logic ev_rise, ev_fall, ev_start, ev_stop, sda_lvl;

    i2c_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    i2c_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_cmd_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start),
        .ev_stop(ev_stop), .sda_lvl(sda_lvl)
    );

    i2c_cmd_engine #(.RES_W(RES_W), .ADDR_PREFIX(ADDR_PREFIX)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start),
        .ev_stop(ev_stop), .sda_lvl(sda_lvl),
        .strap_i(strap_i), .result_i(result_i),
        .sda_oe_o(sda_oe_o), .chan_o(chan_o), .pd_o(pd_o), .res8_o(res8_o),
        .acq_start_o(acq_start_o), .acq_end_o(acq_end_o)
    );

endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk
    import i2c_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_fall,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              sda_oe_o,
    input logic [CHAN_W-1:0] chan_o,
    input logic              acq_start_o,
    input logic              acq_end_o
);

    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           open_q <= 1'b0;
        else if (acq_start_o) open_q <= 1'b1;
        else if (acq_end_o)   open_q <= 1'b0;
    end

    a_r12_oe_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> $past(ev_fall | ev_start | ev_stop));

    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe_o);

    a_r5_start_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start_o |-> !open_q);

    a_r6_end_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        acq_end_o |-> open_q);

    a_r6_end_on_bus_event: assert property (@(posedge clk) disable iff (!rst_n)
        acq_end_o |-> $past(ev_start | ev_stop));

    a_r4_chan_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_o != $past(chan_o)) |-> acq_start_o);

endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_fall(ev_fall), .ev_start(ev_start),
    .ev_stop(ev_stop), .sda_oe_o(sda_oe_o), .chan_o(chan_o),
    .acq_start_o(acq_start_o), .acq_end_o(acq_end_o)
);

// File: tb/sim_i2c_cmd_slave.sv
`timescale 1ns/1ps
module sim_i2c_cmd_slave;

    localparam int Q = 8;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [1:0]  strap = 2'b00;
    logic [11:0] result = '0;
    logic [3:0]  chan;
    logic [1:0]  pd;
    logic        res8;
    logic        acq_start, acq_end;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_end = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .result_i(result),
        .chan_o(chan), .pd_o(pd), .res8_o(res8),
        .acq_start_o(acq_start), .acq_end_o(acq_end)
    );

    always @(posedge clk) begin
        if (acq_start) n_start <= n_start + 1;
        if (acq_end)   n_end   <= n_end + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [11:0] v, input bit lo);
        return lo ? {v[3:0], 4'b0000} : v[11:4];
    endfunction

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
        return {5'b10010, s, rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wbit(input bit b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output bit b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit nack);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(nack);
    endtask

    task automatic rbyte(input bit master_nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            rbit(b);
            v[i] = b;
        end
        wbit(master_nack);
    endtask

    initial begin
        #(WATCHDOG * 5.0);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit nk;
        bit b;
        logic [7:0] rb;
        int s0, e0;
        void'($urandom(32'h5EED_0042));
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk(!sda_oe && chan == 0 && pd == 0 && !res8, "R1 reset outputs", {sda_oe, chan, pd, res8}, 0);
        chk(n_start == 0 && n_end == 0, "R1 no strobes", n_start + n_end, 0);

        // R2 wrong address ignored
        strap = 2'b10;
        bus_start();
        wbyte(addr_byte(2'b01, 1'b0), nk);
        chk(nk == 1'b1, "R2 mismatched strap not acked", nk, 1);
        wbyte(8'hF0, nk);
        chk(nk == 1'b1 && n_start == 0, "R2 no response after mismatch", n_start, 0);
        bus_stop();
        bus_start();
        wbyte(8'b1101_1000, nk);
        chk(nk == 1'b1, "R2 mismatched prefix not acked", nk, 1);
        bus_stop();

        // R5 strobe timing within command byte, R4 fields
        bus_start();
        wbyte(addr_byte(strap, 1'b0), nk);
        chk(nk == 1'b0, "R2 matching address acked", nk, 0);
        wbit(1); wbit(0); wbit(1);
        chk(n_start == 0, "R5 no strobe after third bit", n_start, 0);
        wbit(1);
        chk(n_start == 1, "R5 strobe after fourth bit", n_start, 1);
        chk(chan == 4'hB, "R4 channel with strobe", chan, 4'hB);
        chk(pd == 0 && res8 == 0, "R4 pd/mode not yet updated", {pd, res8}, 0);
        wbit(1); wbit(0); wbit(1); wbit(1);
        rbit(nk);
        chk(nk == 1'b0, "R7 first command byte acked", nk, 0);
        chk(pd == 2'b10 && res8 == 1'b1, "R4 pd and mode", {pd, res8}, 3'b101);
        // R7 extra byte not acked, fields unchanged
        wbyte(8'h46, nk);
        chk(nk == 1'b1, "R7 second byte not acked", nk, 1);
        chk(chan == 4'hB && pd == 2'b10 && res8 && n_start == 1, "R7 fields kept", {chan, pd, res8}, {4'hB, 2'b10, 1'b1});
        chk(n_end == 0, "R6 window still open", n_end, 0);
        bus_stop();
        chk(n_end == 1, "R6 end at stop", n_end, 1);
        chk(!sda_oe, "R3 SDA released after stop", sda_oe, 0);

        // R9 8-bit read repeats byte
        result = 12'hA5C;
        bus_start();
        wbyte(addr_byte(strap, 1'b1), nk);
        chk(nk == 1'b0, "R2 read address acked", nk, 0);
        result = 12'h000;
        rbyte(1'b0, rb);
        chk(rb == 8'hA5, "R8 snapshot at address ack", rb, 8'hA5);
        rbyte(1'b1, rb);
        chk(rb == 8'hA5, "R9 8-bit repeats byte", rb, 8'hA5);
        rbit(b);
        chk(b == 1'b1, "R10 released after master nack", b, 1);
        bus_stop();

        // R6 end at repeated start, R4 bit 0 ignored
        bus_start();
        wbyte(addr_byte(strap, 1'b0), nk);
        wbyte(8'h31, nk);
        chk(chan == 4'h3 && pd == 2'b00 && res8 == 1'b0, "R4 trailing bit ignored", {chan, pd, res8}, 7'h18);
        s0 = n_end;
        bus_start();
        chk(n_end == s0 + 1, "R6 end at repeated start", n_end, s0 + 1);

        // R11 repeated start mid-address
        wbit(1); wbit(0); wbit(0);
        bus_start();
        wbyte(addr_byte(strap, 1'b1), nk);
        chk(nk == 1'b0, "R11 address after mid-byte restart", nk, 0);
        result = 12'h000;
        rbyte(1'b1, rb);
        bus_stop();

        // R8 R10 random commands and readback
        for (int it = 0; it < 14; it++) begin
            logic [7:0] cmd;
            logic [11:0] val;
            strap = 2'($urandom);
            cmd = 8'($urandom);
            val = 12'($urandom);
            s0 = n_start;
            e0 = n_end;
            bus_start();
            wbyte(addr_byte(strap, 1'b0), nk);
            wbyte(cmd, nk);
            chk(nk == 1'b0 && n_start == s0 + 1, "R5 random command strobe", n_start, s0 + 1);
            chk(chan == cmd[7:4] && pd == cmd[3:2] && res8 == cmd[1], "R4 random fields",
                {chan, pd, res8}, cmd[7:1]);
            bus_stop();
            chk(n_end == e0 + 1, "R6 random end", n_end, e0 + 1);
            result = val;
            bus_start();
            wbyte(addr_byte(strap, 1'b1), nk);
            rbyte(1'b0, rb);
            chk(rb == exp_byte(val, 1'b0), "R8 high byte", rb, exp_byte(val, 1'b0));
            rbyte(1'b0, rb);
            chk(rb == exp_byte(val, !cmd[1]), "R10 second byte", rb, exp_byte(val, !cmd[1]));
            rbyte(1'b1, rb);
            chk(rb == exp_byte(val, 1'b0), "R10 third byte", rb, exp_byte(val, 1'b0));
            rbit(b);
            chk(b == 1'b1 && !sda_oe, "R10 idle after nack", b, 1);
            bus_stop();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule